// File: doc/BRIEF.md
# Randomized Thermometer Unit Selector

This block drives a DAC built from 2^B−1 equal unit cells. Each accepted B-bit input code turns into a one-bit-per-cell enable vector in which exactly as many cells are on as the code value. The code range 0..2^B−1 therefore spans every cell count from none to all.

With dynamic element matching switched off, the block uses the plain thermometer mapping. With it switched on, the run of active cells is rotated by a pseudo-random start position that changes on every rising clock edge. The start position comes from an internal LFSR. Rotating the run spreads the error from mismatched cells into broadband noise instead of harmonics. The active cells always form one circularly contiguous run, so no cell is ever counted twice. The LFSR seed can be loaded, and the same seed always reproduces the same sequence.

Codes arrive on a valid/ready stream and vectors leave on one. Input ready is high whenever the output register is empty or is being read in the same cycle. A stalled output holds its vector and drops input ready, so no code is lost or overwritten. The mode enable and the seed-load controls are plain level or pulse pins.

Top module: `rts_unit_selector`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid is low, units is all zero and in_ready is high.
- R2: For every accepted code, the vector delivered for it has exactly code bits set, in either mode.
- R3: With dem_en low, the delivered vector has bit i set if and only if i < code.
- R4: Code 0 gives an all-zero vector and code 2^B−1 gives an all-ones vector, in either mode.
- R5: With dem_en high, the set bits of every vector for a code between 1 and 2^B−2 form exactly one circularly contiguous run over the cell indices 0..2^B−2.
- R6: With dem_en high, the run start position changes from clock to clock: over 200 transfers of code 1, at least 12 of the 15 cell positions are seen, and at least one vector differs from the thermometer code.
- R7: A seed_load pulse with a given seed followed by the same transfer timing produces the same vector sequence every time, and a different seed produces a different sequence.
- R8: A code accepted with in_valid and in_ready high appears on units with out_valid one cycle later. While out_valid is high and out_ready is low, units stays stable, out_valid stays high and in_ready is low.
- R9: Loading a seed of zero substitutes a fixed non-zero seed, and the rotation keeps changing afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every rising edge advances the shuffle |
| rst | input | 1 | Synchronous active-high reset; restores the identity mapping |
| dem_en | input | 1 | 1 = rotate the active run at random, 0 = plain thermometer |
| seed_load | input | 1 | Single-cycle pulse that loads seed into the LFSR and clears the rotation |
| seed | input | LFSR_W (16) | LFSR seed; 0 is replaced by a fixed non-zero value |
| in_valid | input | 1 | Input code is valid |
| in_ready | output | 1 | Block can accept a code this cycle |
| in_code | input | CODE_W (4) | Number of cells to turn on |
| out_valid | output | 1 | units holds a delivered vector |
| out_ready | input | 1 | Downstream takes the vector this cycle |
| units | output | 2^CODE_W−1 (15) | One enable bit per physical unit cell |

## Verification
The bench targets the extremes of the code range with the shuffle running. A rotation that leaked into codes 0 or 15 would light a stray cell or drop one. It checks every shuffled vector for a single circular run with the right population. An off-by-one in the wrap index would split the run or duplicate a cell. It measures how widely code 1 moves, so a stuck or short-period generator shows up as too few positions. Stalls with a new code waiting would expose a design that overwrites a held vector. Replaying a seed, and loading seed zero, catch a generator that is not fully reset by the load or that locks up at all zeros.

// File: rtl/rts_pkg.sv
package rts_pkg;
  // Default sizing shared by the selector and its bench.
  localparam int DEF_CODE_W = 4;
  localparam int DEF_LFSR_W = 16;
  // Seed used on reset and whenever a zero seed is loaded.
  localparam logic [DEF_LFSR_W-1:0] DEF_FALLBACK_SEED = 16'hACE1;
  localparam logic [DEF_LFSR_W-1:0] DEF_LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/rts_lfsr.sv
module rts_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] FALLBACK = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] step;

  // Galois form, shifting right.
  always_comb begin
    step = state_q >> 1;
    if (state_q[0]) step = step ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (rst)         state_q <= FALLBACK;
    else if (load_i) state_q <= (seed_i == '0) ? FALLBACK : seed_i;
    else             state_q <= step;
  end

  assign state_o = state_q;

  // A zero state would freeze the shuffle.
  assert_lfsr_live_R9: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
endmodule

// File: rtl/rts_offset_gen.sv
module rts_offset_gen #(
  parameter int CODE_W = 4,
  parameter int LFSR_W = 16,
  localparam int N = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dem_en_i,
  input  logic              clr_i,
  input  logic [LFSR_W-1:0] rand_i,
  output logic [CODE_W-1:0] offset_o
);
  logic [CODE_W-1:0] raw;
  logic [CODE_W-1:0] folded;
  logic [CODE_W-1:0] offset_q;

  // Fold the single out-of-range value back into 0..N-1.
  assign raw    = rand_i[CODE_W-1:0];
  assign folded = (raw >= CODE_W'(N)) ? raw - CODE_W'(N) : raw;

  always_ff @(posedge clk) begin
    if (rst || clr_i || !dem_en_i) offset_q <= '0;
    else                           offset_q <= folded;
  end

  assign offset_o = offset_q;

  assert_offset_range_R5: assert property (@(posedge clk) disable iff (rst)
    offset_q < CODE_W'(N));
  assert_offset_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !dem_en_i |=> offset_q == '0);
endmodule

// File: rtl/rts_rotate_map.sv
module rts_rotate_map #(
  parameter int CODE_W = 4,
  localparam int N = (1 << CODE_W) - 1
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] offset_i,
  output logic [N-1:0]      units_o
);
  // Cell i takes thermometer position (i - offset) mod N.
  for (genvar i = 0; i < N; i++) begin : g_cell
    always_comb begin
      int src;
      if (i >= int'(offset_i)) src = i - int'(offset_i);
      else                     src = i + N - int'(offset_i);
      units_o[i] = (src < int'(code_i));
    end
  end
endmodule

// File: rtl/rts_unit_selector.sv
module rts_unit_selector #(
  parameter int CODE_W = rts_pkg::DEF_CODE_W,
  parameter int LFSR_W = rts_pkg::DEF_LFSR_W,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = rts_pkg::DEF_LFSR_TAPS,
  parameter logic [LFSR_W-1:0] FALLBACK_SEED = rts_pkg::DEF_FALLBACK_SEED,
  localparam int N = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dem_en,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [N-1:0]      units
);
  logic [LFSR_W-1:0] rand_w;
  logic [CODE_W-1:0] offset_w;
  logic [N-1:0]      map_w;
  logic [N-1:0]      units_q;
  logic [CODE_W-1:0] code_q;
  logic              valid_q;
  logic              take;

  rts_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .FALLBACK(FALLBACK_SEED)) lfsr_i (
    .clk(clk), .rst(rst), .load_i(seed_load), .seed_i(seed), .state_o(rand_w));

  rts_offset_gen #(.CODE_W(CODE_W), .LFSR_W(LFSR_W)) offs_i (
    .clk(clk), .rst(rst), .dem_en_i(dem_en), .clr_i(seed_load),
    .rand_i(rand_w), .offset_o(offset_w));

  rts_rotate_map #(.CODE_W(CODE_W)) map_i (
    .code_i(in_code), .offset_i(offset_w), .units_o(map_w));

  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      units_q <= '0;
      code_q  <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (take) begin
        units_q <= map_w;
        code_q  <= in_code;
      end
    end
  end

  assign out_valid = valid_q;
  assign units     = units_q;

  assert_count_R2: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> $countones(units_q) == int'(code_q));
  assert_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_q && code_q == '0) |-> units_q == '0);
  assert_full_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_q && code_q == CODE_W'(N)) |-> units_q == '1);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !out_ready) |=> (valid_q && $stable(units_q)));
  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> (valid_q && code_q == $past(in_code)));
endmodule

// File: tb/rts_unit_selector_tb_top.sv
`timescale 1ns/1ps
module rts_unit_selector_tb_top;
  localparam int CW = 4;
  localparam int LW = 16;
  localparam int N  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dem_en = 1'b0, seed_load = 1'b0;
  logic [LW-1:0] seed = '0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [CW-1:0] in_code = '0;
  logic in_ready, out_valid;
  logic [N-1:0] units;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rts_unit_selector dut_i (
    .clk(clk), .rst(rst), .dem_en(dem_en), .seed_load(seed_load), .seed(seed),
    .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code),
    .out_valid(out_valid), .out_ready(out_ready), .units(units));

  function automatic int popc(logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic [N-1:0] thermo(int code);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = (i < code);
    return v;
  endfunction

  function automatic int rising_edges(logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) if (v[i] && !v[(i + N - 1) % N]) c++;
    return c;
  endfunction

  function automatic int first_set(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One transfer: offer code for one cycle, read the result a cycle later.
  task automatic xfer(input int code, output logic [N-1:0] res, output bit vld);
    @(negedge clk);
    in_valid = 1'b1; in_code = CW'(code);
    @(negedge clk);
    in_valid = 1'b0;
    res = units; vld = out_valid;
  endtask

  task automatic load_seed(input logic [LW-1:0] s);
    @(negedge clk); seed_load = 1'b1; seed = s;
    @(negedge clk); seed_load = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r, ra[16], rb[16];
    bit v, ok;
    int seen[N];
    int nseen, code;
    void'($urandom(32'd4711));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!out_valid && units == '0 && in_ready, "R1", "during reset", units, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && units == '0 && in_ready, "R1", "after reset", units, '0);

    // R3/R2: plain mode, directed and random codes
    dem_en = 1'b0;
    @(negedge clk);
    ok = 1;
    for (int k = 0; k < 40; k++) begin
      code = (k < 16) ? k : int'($urandom_range(0, N));
      xfer(code, r, v);
      if (!v || r != thermo(code)) begin
        ok = 0;
        check(0, "R3", $sformatf("plain code %0d", code), r, thermo(code));
      end
    end
    check(ok, "R3", "plain thermometer sweep", '0, '0);

    // R4 in plain mode
    xfer(0, r, v);  check(v && r == '0, "R4", "code 0 plain", r, '0);
    xfer(N, r, v);  check(v && r == '1, "R4", "code max plain", r, '1);

    // R2/R5/R4 with shuffle on
    dem_en = 1'b1;
    @(negedge clk);
    ok = 1;
    for (int k = 0; k < 300; k++) begin
      code = int'($urandom_range(0, N));
      xfer(code, r, v);
      if (!v || popc(r) != code) begin
        ok = 0;
        check(0, "R2", $sformatf("count code %0d", code), r, thermo(code));
      end
      if (code > 0 && code < N && rising_edges(r) != 1) begin
        ok = 0;
        check(0, "R5", $sformatf("run code %0d", code), r, thermo(code));
      end
    end
    check(ok, "R2", "shuffled population sweep", '0, '0);
    xfer(0, r, v);  check(v && r == '0, "R4", "code 0 shuffled", r, '0);
    xfer(N, r, v);  check(v && r == '1, "R4", "code max shuffled", r, '1);
    xfer(N - 1, r, v);
    check(v && popc(r) == N - 1 && rising_edges(r) == 1, "R5", "code max-1 run", r, thermo(N - 1));

    // R6: spread of code 1
    for (int i = 0; i < N; i++) seen[i] = 0;
    ok = 0;
    for (int k = 0; k < 200; k++) begin
      xfer(1, r, v);
      if (first_set(r) >= 0) seen[first_set(r)] = 1;
      if (r != thermo(1)) ok = 1;
    end
    nseen = 0;
    for (int i = 0; i < N; i++) nseen += seen[i];
    check(nseen >= 12, "R6", $sformatf("positions seen %0d", nseen), N'(nseen), N'(12));
    check(ok, "R6", "some vector off thermometer", '0, '1);

    // R7: seed replay
    load_seed(16'h1D2F);
    for (int k = 0; k < 16; k++) xfer((k * 5 + 3) % 16, ra[k], v);
    load_seed(16'h1D2F);
    for (int k = 0; k < 16; k++) xfer((k * 5 + 3) % 16, rb[k], v);
    ok = 1;
    for (int k = 0; k < 16; k++) if (ra[k] != rb[k]) ok = 0;
    check(ok, "R7", "same seed replays", rb[0], ra[0]);
    load_seed(16'h7351);
    for (int k = 0; k < 16; k++) xfer((k * 5 + 3) % 16, rb[k], v);
    ok = 0;
    for (int k = 0; k < 16; k++) if (ra[k] != rb[k]) ok = 1;
    check(ok, "R7", "different seed differs", rb[0], ra[0]);

    // R9: zero seed does not lock the shuffle
    load_seed('0);
    for (int i = 0; i < N; i++) seen[i] = 0;
    for (int k = 0; k < 60; k++) begin
      xfer(1, r, v);
      if (first_set(r) >= 0) seen[first_set(r)] = 1;
    end
    nseen = 0;
    for (int i = 0; i < N; i++) nseen += seen[i];
    check(nseen >= 4, "R9", $sformatf("positions after zero seed %0d", nseen), N'(nseen), N'(4));

    // R8: latency and stall
    dem_en = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_code = CW'(5);
    @(negedge clk);
    check(out_valid && units == thermo(5), "R8", "one-cycle latency", units, thermo(5));
    check(!in_ready, "R8", "in_ready low while stalled", N'(in_ready), '0);
    in_code = CW'(9);
    @(negedge clk);
    check(out_valid && units == thermo(5), "R8", "held while stalled", units, thermo(5));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && units == thermo(9), "R8", "next code after release", units, thermo(9));
    @(negedge clk);
    check(!out_valid, "R8", "valid drops when idle", N'(out_valid), '0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule